// File: doc/BRIEF.md
# Software Command Address-Sequence Detector

This block watches the completed accesses of an SRAM port and picks out a fixed series of six reads. The reads work as a command channel that software can reach with ordinary loads. The first five reads must hit five fixed addresses, always in the same order. The sixth read chooses one of four nonvolatile commands: store, recall, autostore disable or autostore enable. When the series completes, the block raises a pulse one clock long on the output for that command.

Only a 13-bit slice of the address, bits 14 down to 2, takes part in the match. Any write, or any read that does not fit the series, throws the partial series away. An access made while the port is marked busy, during a store or recall or at low supply, is not seen at all. The data path and the execution of each command stay outside this block.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: Completed reads whose address slice equals, in this exact order, the keys of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F form the prefix, and idle cycles (acc_vld_i low) between them have no effect.
- R2: A sixth read after a full prefix picks the command: 0x8FC0 pulses cmd_store_o, 0x4C63 pulses cmd_recall_o, 0x8B45 pulses cmd_as_off_o and 0x4B46 pulses cmd_as_on_o.
- R3: Only address bits 14 down to 2 are compared. Bits 18 to 15 and bits 1 to 0 have no effect, and flipping bit 2 of any sequence address breaks the match.
- R4: A completed write (acc_wr_i high) at any step aborts the series, and a write never advances it.
- R5: A read that does not match the expected address aborts the series. If that read equals the first prefix address, it counts as step one of a new series.
- R6: An access with busy_i high is ignored. It neither advances nor aborts the series.
- R7: A sixth read that matches no command aborts the series and gives no pulse.
- R8: A command output goes high in the cycle after the sixth read is taken and stays high for exactly one cycle. At most one command output is high at a time.
- R9: Reset clears the series and drives all outputs low. After a command the series is back at idle, so a lone command address gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | Pulse marking one completed port access |
| acc_wr_i | input | 1 | High when the access is a write |
| acc_addr_i | input | 19 | Address of the access |
| busy_i | input | 1 | Store, recall or low supply in progress; accesses are ignored |
| cmd_store_o | output | 1 | Nonvolatile store command pulse |
| cmd_recall_o | output | 1 | Nonvolatile recall command pulse |
| cmd_as_off_o | output | 1 | Autostore disable command pulse |
| cmd_as_on_o | output | 1 | Autostore enable command pulse |

## Verification
The hardest case to reach from the ports is a broken series that must still count one of its reads as a fresh start. This happens when an aborting read is itself the first prefix address, partway through or at the sixth position. The bench builds a three-read partial prefix, inserts the first address, and then completes the series only from step two. A store pulse then proves that the restart was taken. Busy-marked reads and writes are also slipped into the middle of a prefix, to show that they leave the partial series untouched.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int PRE_N  = 5;
  localparam int CMD_N  = 4;
  localparam int CODE_W = 16;

  // Prefix order is behaviour: index = step
  localparam logic [CODE_W-1:0] PRE_CODES [PRE_N] = '{
    16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F
  };

  typedef enum logic [1:0] {
    CMD_STORE  = 2'd0,
    CMD_RECALL = 2'd1,
    CMD_AS_OFF = 2'd2,
    CMD_AS_ON  = 2'd3
  } cmd_e;

  // Index matches cmd_e
  localparam logic [CODE_W-1:0] CMD_CODES [CMD_N] = '{
    16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46
  };
endpackage

// File: rtl/nvcmd_key_match.sv
module nvcmd_key_match
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int KEY_LO = 2,
  parameter int KEY_HI = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PRE_N-1:0]  pre_hit_o,
  output logic [CMD_N-1:0]  cmd_hit_o
);
  localparam int KEY_W = KEY_HI - KEY_LO + 1;

  logic [KEY_W-1:0] key;
  assign key = addr_i[KEY_HI:KEY_LO];

  for (genvar gi = 0; gi < PRE_N; gi++) begin : g_pre
    localparam logic [CODE_W-1:0] CODE = PRE_CODES[gi];
    assign pre_hit_o[gi] = (key == CODE[KEY_HI:KEY_LO]);
  end

  for (genvar gc = 0; gc < CMD_N; gc++) begin : g_cmd
    localparam logic [CODE_W-1:0] CODE = CMD_CODES[gc];
    assign cmd_hit_o[gc] = (key == CODE[KEY_HI:KEY_LO]);
  end

  always_comb begin
    assert ($onehot0(cmd_hit_o)) else $error("a_r2_cmd_keys_distinct");
  end
endmodule

// File: rtl/nvcmd_seq_ctrl.sv
module nvcmd_seq_ctrl
  import nvcmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_vld_i,
  input  logic             acc_wr_i,
  input  logic             busy_i,
  input  logic [PRE_N-1:0] pre_hit_i,
  input  logic [CMD_N-1:0] cmd_hit_i,
  output logic             fire_o,
  output logic [CMD_N-1:0] fire_sel_o
);
  localparam int STEP_W = $clog2(PRE_N + 1);
  localparam logic [STEP_W-1:0] TAIL = STEP_W'(PRE_N);

  logic [STEP_W-1:0] step_q, step_d;
  logic take, at_tail, pre_ok;

  assign take    = acc_vld_i & ~busy_i;
  assign at_tail = (step_q == TAIL);
  assign pre_ok  = !at_tail && pre_hit_i[step_q];

  always_comb begin
    step_d     = step_q;
    fire_o     = 1'b0;
    fire_sel_o = '0;
    if (take) begin
      if (acc_wr_i) begin
        step_d = '0;
      end else if (at_tail && (|cmd_hit_i)) begin
        fire_o     = 1'b1;
        fire_sel_o = cmd_hit_i;
        step_d     = '0;
      end else if (pre_ok) begin
        step_d = step_q + 1'b1;
      end else if (pre_hit_i[0]) begin
        step_d = STEP_W'(1);  // restart: this read is step one
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  a_r1_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= TAIL);
  a_r6_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && busy_i) |=> $stable(step_q));
  a_r4_write_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && !busy_i && acc_wr_i) |=> (step_q == '0));
  a_r9_idle_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (step_q == '0));
endmodule

// File: rtl/nvcmd_pulse_out.sv
module nvcmd_pulse_out
  import nvcmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [CMD_N-1:0] fire_sel_i,
  output logic [CMD_N-1:0] cmd_o
);
  logic [CMD_N-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (fire_i) cmd_q <= fire_sel_i;
    else             cmd_q <= '0;
  end

  assign cmd_o = cmd_q;

  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_q));
  a_r8_from_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cmd_q != '0));
  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q != '0) |=> ((cmd_q & $past(cmd_q)) == '0));
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int KEY_LO = 2,
  parameter int KEY_HI = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_vld_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              busy_i,
  output logic              cmd_store_o,
  output logic              cmd_recall_o,
  output logic              cmd_as_off_o,
  output logic              cmd_as_on_o
);
  logic [PRE_N-1:0] pre_hit;
  logic [CMD_N-1:0] cmd_hit, fire_sel, cmd_vec;
  logic             fire;

  nvcmd_key_match #(
    .ADDR_W(ADDR_W), .KEY_LO(KEY_LO), .KEY_HI(KEY_HI)
  ) u_match (
    .addr_i    (acc_addr_i),
    .pre_hit_o (pre_hit),
    .cmd_hit_o (cmd_hit)
  );

  nvcmd_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_vld_i  (acc_vld_i),
    .acc_wr_i   (acc_wr_i),
    .busy_i     (busy_i),
    .pre_hit_i  (pre_hit),
    .cmd_hit_i  (cmd_hit),
    .fire_o     (fire),
    .fire_sel_o (fire_sel)
  );

  nvcmd_pulse_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .fire_sel_i (fire_sel),
    .cmd_o      (cmd_vec)
  );

  assign cmd_store_o  = cmd_vec[CMD_STORE];
  assign cmd_recall_o = cmd_vec[CMD_RECALL];
  assign cmd_as_off_o = cmd_vec[CMD_AS_OFF];
  assign cmd_as_on_o  = cmd_vec[CMD_AS_ON];

  a_r6_busy_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && busy_i) |=> (cmd_vec == '0));
  a_r4_write_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && acc_wr_i) |=> (cmd_vec == '0));
endmodule

// File: tb/nvcmd_seq_detect_tb.sv
module nvcmd_seq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, wr = 1'b0, busy = 1'b0;
  logic [18:0] addr = '0;
  logic        st, rc, aoff, aon;
  logic [3:0]  got;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  // Command bit order in checks: {as_on, as_off, recall, store}
  localparam logic [15:0] P0 = 16'h4E38, P1 = 16'hB1C7, P2 = 16'h83E0,
                          P3 = 16'h7C1F, P4 = 16'h703F;
  localparam logic [15:0] C_ST = 16'h8FC0, C_RC = 16'h4C63,
                          C_OFF = 16'h8B45, C_ON = 16'h4B46;

  always #5 clk = ~clk;

  nvcmd_seq_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(vld), .acc_wr_i(wr),
    .acc_addr_i(addr), .busy_i(busy),
    .cmd_store_o(st), .cmd_recall_o(rc), .cmd_as_off_o(aoff), .cmd_as_on_o(aon)
  );

  function automatic logic [3:0] outs();
    return {aon, aoff, rc, st};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // One access; got holds outputs in the cycle after it is taken
  task automatic acc(logic [18:0] a, logic w, logic b);
    @(negedge clk);
    vld = 1'b1; wr = w; busy = b; addr = a;
    @(negedge clk);
    got = outs();
    vld = 1'b0; wr = 1'b0; busy = 1'b0;
  endtask

  task automatic rd(logic [18:0] a);
    acc(a, 1'b0, 1'b0);
  endtask

  task automatic prefix();
    rd({3'b0, P0}); rd({3'b0, P1}); rd({3'b0, P2});
    rd({3'b0, P3}); rd({3'b0, P4});
  endtask

  task automatic t_reset();
    chk("R9 reset outputs", outs(), 4'b0000);
  endtask

  task automatic t_each_cmd();
    logic [15:0] codes [4] = '{C_ST, C_RC, C_OFF, C_ON};
    for (int i = 0; i < 4; i++) begin
      prefix();
      chk("R1 no pulse during prefix", got, 4'b0000);
      rd({3'b0, codes[i]});
      chk("R2 command select", got, 4'(1 << i));
      @(negedge clk);
      chk("R8 pulse lasts one cycle", outs(), 4'b0000);
    end
  endtask

  task automatic t_idle_gaps();
    rd({3'b0, P0}); repeat (3) @(negedge clk);
    rd({3'b0, P1}); rd({3'b0, P2}); repeat (2) @(negedge clk);
    rd({3'b0, P3}); rd({3'b0, P4}); @(negedge clk);
    rd({3'b0, C_RC});
    chk("R1 idle gaps keep series", got, 4'b0010);
  endtask

  task automatic t_slice();
    logic [18:0] fl = 19'h78003;
    rd({3'b0, P0} ^ fl); rd({3'b0, P1} ^ fl); rd({3'b0, P2} ^ fl);
    rd({3'b0, P3} ^ fl); rd({3'b0, P4} ^ fl);
    rd({3'b0, C_ON} ^ fl);
    chk("R3 outside bits ignored", got, 4'b1000);
    prefix();
    rd({3'b0, C_ST} ^ 19'h4);
    chk("R3 bit 2 compared", got, 4'b0000);
  endtask

  task automatic t_write_abort();
    rd({3'b0, P0}); rd({3'b0, P1}); rd({3'b0, P2});
    acc({3'b0, P3}, 1'b1, 1'b0);
    rd({3'b0, P4}); rd({3'b0, C_ST});
    chk("R4 write aborts", got, 4'b0000);
    prefix();
    acc({3'b0, C_ST}, 1'b1, 1'b0);
    chk("R4 write as sixth no cmd", got, 4'b0000);
    rd({3'b0, C_ST});
    chk("R4 write cleared series", got, 4'b0000);
  endtask

  task automatic t_mismatch();
    rd({3'b0, P0}); rd({3'b0, P1}); rd(19'h01234);
    rd({3'b0, P2}); rd({3'b0, P3}); rd({3'b0, P4}); rd({3'b0, C_ST});
    chk("R5 stray read aborts", got, 4'b0000);
    rd({3'b0, P0}); rd({3'b0, P1}); rd({3'b0, P2});
    rd({3'b0, P0});
    rd({3'b0, P1}); rd({3'b0, P2}); rd({3'b0, P3}); rd({3'b0, P4});
    rd({3'b0, C_ST});
    chk("R5 restart at step two", got, 4'b0001);
  endtask

  task automatic t_busy();
    rd({3'b0, P0}); rd({3'b0, P1}); rd({3'b0, P2});
    acc(19'h05555, 1'b0, 1'b1);
    acc({3'b0, P0}, 1'b1, 1'b1);
    rd({3'b0, P3}); rd({3'b0, P4});
    acc({3'b0, C_ST}, 1'b0, 1'b1);
    chk("R6 busy sixth no cmd", got, 4'b0000);
    rd({3'b0, C_OFF});
    chk("R6 busy accesses ignored", got, 4'b0100);
  endtask

  task automatic t_bad_sixth();
    prefix();
    rd(19'h01111);
    chk("R7 unknown sixth no cmd", got, 4'b0000);
    rd({3'b0, C_ST});
    chk("R7 unknown sixth aborted", got, 4'b0000);
  endtask

  task automatic t_after_cmd();
    prefix(); rd({3'b0, C_ST});
    chk("R9 first cmd", got, 4'b0001);
    rd({3'b0, C_RC});
    chk("R9 idle after cmd", got, 4'b0000);
    prefix();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd({3'b0, C_ST});
    chk("R9 reset clears series", got, 4'b0000);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_cmd();
    t_idle_gaps();
    t_slice();
    t_write_abort();
    t_mismatch();
    t_busy();
    t_bad_sixth();
    t_after_cmd();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule